// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block takes one byte at a time from a valid/ready load port and sends it on a single output line as an asynchronous frame. The line idles high. A frame is a low start bit, then a group of 7 or 8 bits sent least significant bit first, then one or two high stop bits. When parity is on, the parity bit does not extend the frame. It takes the top position of the group, so a 7-bit group with parity carries six data bits.

A divisor input gives the number of system clock cycles in each bit. Every cycle of the frame is timed from that divisor. The divisor and the frame format are both captured when a byte is accepted, so they can change while a frame is on the line without disturbing it. A host writes a byte by raising the valid input. The byte is taken on the first clock edge at which the ready output is also high.

Top module: `uart_tx_top`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1 and `in_ready` is 1.
- R2: A byte is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From that edge onward, `tx_line` sends the start bit (0), then the group bits with bit 0 first, then the stop bits (1).
- R3: Every bit of the frame, including the start and stop bits, stays on `tx_line` for exactly D clock cycles, where D is the divisor captured at acceptance. The start bit begins with the accepting edge.
- R4: When `cfg_eight` is 1 the group is 8 bits. When it is 0 the group is 7 bits and `in_data[7]` is never sent.
- R5: When `cfg_par_en` is 1, the most significant bit of the group (bit 7 for 8-bit groups, bit 6 for 7-bit groups) is replaced by a parity bit computed over the lower group bits. With `cfg_par_odd` = 0 the count of ones in the whole group is even. With `cfg_par_odd` = 1 that count is odd.
- R6: `cfg_two_stop` = 0 gives one stop bit and `cfg_two_stop` = 1 gives two stop bits.
- R7: `in_ready` is 0 from the accepting edge until the frame ends. Any `in_valid` or `in_data` activity during that time has no effect on the frame being sent.
- R8: The divisor and all four format inputs are captured at acceptance. Changing them during a frame does not change that frame.
- R9: `in_ready` returns to 1 on the edge that ends the last stop bit. A byte presented right away is accepted on the next edge, and its start bit follows with no extra idle bit time.
- R10: A divisor of 0 behaves like a divisor of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div | input | DIV_W | Clock cycles per bit (0 is treated as 1) |
| cfg_eight | input | 1 | 1: 8-bit group, 0: 7-bit group |
| cfg_par_en | input | 1 | 1: top group bit is parity |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| in_valid | input | 1 | Byte offered on in_data |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Transmitter idle and able to accept |
| tx_line | output | 1 | Serial output line |

## Verification
The bench compares `tx_line` against the expected frame on every clock cycle. This means a bit that is one cycle short or long, an off-by-one divisor count, or a late start bit all show up as a mismatch. The corner cases are:
- Parity for both 7-bit and 8-bit groups with both polarities. A design that appends parity instead of replacing the top bit, or that uses the wrong polarity, sends a wrong bit or a frame of the wrong length.
- A 7-bit group with `in_data[7]` set, which catches a design that leaks that bit.
- Divisors of 1 and 0. A design without the clamp for 0 would hang or wrap its counter.
- Frames where the format inputs, the divisor and valid with a new byte all change mid-frame. These catch a design that samples its format live or accepts while busy.
- Back-to-back frames, which catch an extra idle gap or a lost byte.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int GRP_MAX = 8;
    localparam int IDX_W   = $clog2(GRP_MAX);

    typedef struct packed {
        logic wide;      // 1: 8-bit group
        logic par_en;    // parity replaces top group bit
        logic par_odd;   // 1: odd parity
        logic two_stop;  // 1: two stop bits
    } tx_fmt_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_t;

    // Index of the most significant bit of the group
    function automatic logic [IDX_W-1:0] group_top(input tx_fmt_t f);
        return f.wide ? IDX_W'(GRP_MAX - 1) : IDX_W'(GRP_MAX - 2);
    endfunction

    // Build the group: mask unused bit, insert parity at the top position
    function automatic logic [GRP_MAX-1:0] build_group(input logic [GRP_MAX-1:0] d,
                                                        input tx_fmt_t f);
        logic [GRP_MAX-1:0] g;
        logic [IDX_W-1:0]   top;
        logic               p;
        top = group_top(f);
        g   = d;
        if (!f.wide) g[GRP_MAX-1] = 1'b0;
        p = f.par_odd;
        for (int i = 0; i < GRP_MAX - 1; i++) begin
            if (i < int'(top)) p = p ^ d[i];
        end
        if (f.par_en) g[top] = p;
        return g;
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim_m1;

    always_comb begin
        lim_m1 = (div_q == '0) ? '0 : div_q - 1'b1;
        tick   = run && (cnt == lim_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= DIV_W'(1);
            cnt   <= '0;
        end else if (restart) begin
            div_q <= div_in;
            cnt   <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_grouper.sv
module uart_tx_grouper
    import uart_tx_pkg::*;
(
    input  logic [GRP_MAX-1:0] data,
    input  tx_fmt_t            fmt,
    output logic [GRP_MAX-1:0] group,
    output logic [IDX_W-1:0]   last_idx
);
    always_comb begin
        group    = build_group(data, fmt);
        last_idx = group_top(fmt);
    end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
    import uart_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [GRP_MAX-1:0] group,
    input  logic [IDX_W-1:0]   last_idx_in,
    input  logic               two_stop_in,
    input  logic               tick,
    output logic               accept,
    output logic               busy,
    output logic               ready,
    output logic               tx
);
    tx_state_t          state;
    logic [GRP_MAX-1:0] shreg;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   last_idx;
    logic               two_stop_q;
    logic               stop_second;
    logic               tx_q;

    always_comb begin
        ready  = (state == ST_IDLE);
        busy   = !ready;
        accept = ready && in_valid;
        tx     = tx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            shreg       <= '0;
            idx         <= '0;
            last_idx    <= '0;
            two_stop_q  <= 1'b0;
            stop_second <= 1'b0;
            tx_q        <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        shreg      <= group;
                        last_idx   <= last_idx_in;
                        two_stop_q <= two_stop_in;
                        idx        <= '0;
                        tx_q       <= 1'b0;
                        state      <= ST_START;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        tx_q  <= shreg[0];
                        shreg <= shreg >> 1;
                        idx   <= '0;
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (idx == last_idx) begin
                            tx_q        <= 1'b1;
                            stop_second <= 1'b0;
                            state       <= ST_STOP;
                        end else begin
                            tx_q  <= shreg[0];
                            shreg <= shreg >> 1;
                            idx   <= idx + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (two_stop_q && !stop_second) stop_second <= 1'b1;
                        else                            state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx_top.sv
module uart_tx_top
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DIV_W-1:0]   div,
    input  logic               cfg_eight,
    input  logic               cfg_par_en,
    input  logic               cfg_par_odd,
    input  logic               cfg_two_stop,
    input  logic               in_valid,
    input  logic [GRP_MAX-1:0] in_data,
    output logic               in_ready,
    output logic               tx_line
);
    tx_fmt_t            fmt;
    logic [GRP_MAX-1:0] group;
    logic [IDX_W-1:0]   last_idx;
    logic               accept;
    logic               busy;
    logic               bit_tick;

    always_comb begin
        fmt.wide     = cfg_eight;
        fmt.par_en   = cfg_par_en;
        fmt.par_odd  = cfg_par_odd;
        fmt.two_stop = cfg_two_stop;
    end

    uart_tx_grouper u_grp (
        .data     (in_data),
        .fmt      (fmt),
        .group    (group),
        .last_idx (last_idx)
    );

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .run     (busy),
        .div_in  (div),
        .tick    (bit_tick)
    );

    uart_tx_frame u_frame (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .group       (group),
        .last_idx_in (last_idx),
        .two_stop_in (fmt.two_stop),
        .tick        (bit_tick),
        .accept      (accept),
        .busy        (busy),
        .ready       (in_ready),
        .tx          (tx_line)
    );
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic tx_line,
    input logic bit_tick
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> tx_line);  // R1

    AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (!tx_line && !in_ready));  // R2

    AST_BIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !bit_tick) |=> $stable(tx_line));  // R3

    AST_TICK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> !in_ready);  // R3

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !bit_tick) |=> !in_ready);  // R7

    AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (in_ready && tx_line));  // R1
endmodule

bind uart_tx_top uart_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_line  (tx_line),
    .bit_tick (bit_tick)
);

// File: tb/uart_tx_top_test.sv
module uart_tx_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] div = 16'd4;
    logic        cfg_eight = 1'b1;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic        cfg_two_stop = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        tx_line;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_tx_top #(.DIV_W(16)) uut (
        .clk          (clk),
        .rst          (rst),
        .div          (div),
        .cfg_eight    (cfg_eight),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .tx_line      (tx_line)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge. Sends one byte and checks every cycle.
    task automatic send(input logic [7:0] d, input bit wide, input bit par,
                        input bit odd, input bit two, input int dv,
                        input bit disturb, input string req);
        logic [11:0] exp_bits;
        logic [7:0]  g;
        logic        p;
        int n, nbits, eff, len;
        bit frame_ok, ready_ok;
        int bad_cyc, bad_act, bad_exp;
        n   = wide ? 8 : 7;
        eff = (dv == 0) ? 1 : dv;
        g   = d;
        if (par) begin
            p = odd;
            for (int i = 0; i < n - 1; i++) p = p ^ d[i];
            g[n-1] = p;
        end
        exp_bits = '1;
        exp_bits[0] = 1'b0;
        for (int i = 0; i < n; i++) exp_bits[1+i] = g[i];
        nbits = 1 + n + (two ? 2 : 1);
        len   = nbits * eff;

        check(in_ready === 1'b1, req, "ready before load", int'(in_ready), 1);
        div = dv[15:0]; cfg_eight = wide; cfg_par_en = par;
        cfg_par_odd = odd; cfg_two_stop = two;
        in_data = d; in_valid = 1'b1;
        @(posedge clk);
        frame_ok = 1'b1; ready_ok = 1'b1;
        bad_cyc = 0; bad_act = 0; bad_exp = 0;
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            if (frame_ok && tx_line !== exp_bits[c / eff]) begin
                frame_ok = 1'b0; bad_cyc = c;
                bad_act = int'(tx_line); bad_exp = int'(exp_bits[c / eff]);
            end
            if (in_ready !== 1'b0) ready_ok = 1'b0;
            if (c == 0) in_valid = 1'b0;
            if (disturb) begin
                if (c == 1) begin
                    // R8: change format and divisor mid-frame
                    div = 16'd2; cfg_eight = ~wide; cfg_par_en = ~par;
                    cfg_par_odd = ~odd; cfg_two_stop = ~two;
                end
                // R7: offer another byte while busy
                in_data  = ~d;
                in_valid = (c >= 1 && c < len - 2);
            end
        end
        in_valid = 1'b0;
        if (!frame_ok)
            $display("FAIL %s tx mismatch at cycle %0d: actual=%0d expected=%0d",
                     req, bad_cyc, bad_act, bad_exp);
        total++;
        if (!frame_ok) bad++;
        check(ready_ok, req, "ready low during frame", int'(ready_ok), 1);
        @(negedge clk);
        check(in_ready === 1'b1 && tx_line === 1'b1, "R9", "idle after frame",
              int'({in_ready, tx_line}), 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line === 1'b1, "R1", "reset line", int'(tx_line), 1);
        check(in_ready === 1'b1, "R1", "reset ready", int'(in_ready), 1);
        repeat (3) @(negedge clk);
        check(tx_line === 1'b1 && in_ready === 1'b1, "R1", "idle hold",
              int'({in_ready, tx_line}), 3);

        send(8'hA5, 1, 0, 0, 0, 4, 0, "R2");  // 8N1 order and timing
        send(8'h3C, 1, 0, 0, 0, 5, 0, "R3");  // odd divisor
        send(8'hF3, 0, 0, 0, 0, 3, 0, "R4");  // 7N1, bit 7 set but unsent
        send(8'h35, 1, 1, 0, 0, 3, 0, "R5");  // 8E1
        send(8'h35, 1, 1, 1, 0, 3, 0, "R5");  // 8O1
        send(8'h4E, 0, 1, 0, 0, 2, 0, "R5");  // 7E1
        send(8'h4E, 0, 1, 1, 0, 2, 0, "R5");  // 7O1
        send(8'h81, 1, 0, 0, 1, 3, 0, "R6");  // 8N2
        send(8'h55, 0, 1, 1, 1, 4, 0, "R6");  // 7O2
        send(8'hC3, 1, 1, 0, 1, 6, 1, "R7");  // busy ignore + latched cfg
        send(8'h1F, 0, 0, 1, 0, 5, 1, "R8");  // latched cfg, 7-bit
        send(8'h96, 1, 0, 0, 0, 1, 0, "R10"); // divisor 1
        send(8'h69, 1, 1, 1, 1, 0, 0, "R10"); // divisor 0 acts as 1
        // back-to-back frames, no idle gap
        send(8'h01, 1, 0, 0, 0, 2, 0, "R9");
        send(8'hFE, 1, 0, 0, 0, 2, 0, "R9");
        send(8'h00, 0, 1, 0, 1, 2, 0, "R9");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule